// File: doc/BRIEF.md
# Programmable Binary Prescaler Timer

This block is a programmable timer built around a binary up-counter that advances on every rising clock edge once it has been started. A two-bit stage select chooses which counter stage is observed, and the block then drives one output pin. The output can be used in either of two ways. As a power-of-two frequency divider, the output follows the chosen stage and gives a square wave. As a one-shot delay, the output makes a single transition once the chosen stage first rises, and a flip-flop holds that level until the timer is started again.

A synchronous master reset restarts the count at any time, so the one-shot delay can be retriggered. A power-up reset window follows the release of `rst_n`. When `auto_reset_disable` is low, that window starts the counter by itself. When it is high, the counter stays idle until a master reset pulse has been applied and removed. A polarity input inverts the output. The counter holds while any reset is active, which stands in for a stopped clock during reset.

Top module: `pbt_timer`

## Requirements
- R1: While `rst_n` is low, `timer_out` is 0 and the counter is cleared and idle.
- R2: For the first `POR_LEN` clock edges after `rst_n` rises, an internal power-up reset acts like a master reset on every edge where `auto_reset_disable` is 0. The window never reopens until `rst_n` is asserted again.
- R3: If no reset has started the counter since `rst_n` was released (for example because `auto_reset_disable` was 1 during the window), the counter does not advance and `timer_out` equals `polarity_sel`.
- R4: The stage tapped is chosen by the code {sel_a,sel_b}. 2'b00 taps stage `TAP_00` (default 13), 2'b01 taps `TAP_01` (10), 2'b10 taps `TAP_10` (8) and 2'b11 taps `TAP_11` (16). Tapping stage N means observing counter bit N-1.
- R5: With `mode`=1, on every clock edge outside reset, `timer_out` is loaded with `polarity_sel` XOR the tapped bit of the count held before that edge. The result is a square wave of period 2^N clocks.
- R6: With `mode`=0, the output flips away from `polarity_sel` on the edge after the one at which the tapped bit first becomes 1. That is 2^(N-1)+1 edges after the last reset edge. The new level then holds until the next reset.
- R7: `polarity_sel`=0 gives a low-to-high one-shot transition. `polarity_sel`=1 inverts the output, so it rests high and falls.
- R8: On every edge where `master_reset` is 1, the counter and the one-shot latch are cleared and `timer_out` takes the value of `polarity_sel`. Counting resumes on the edge after `master_reset` returns to 0, whatever the block was doing.
- R9: Changing {sel_a,sel_b} during a count does not clear the counter. The output simply follows the newly selected stage on the next edge.
- R10: Setting `mode`=1 makes the output follow the tapped bit even after the one-shot has fired. The latch keeps its state, so returning to `mode`=0 shows the fired level again until a reset.
- R11: The counter wraps modulo 2^`CNT_W`, and the divider output continues without a break across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the counter advances on the rising edge |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| master_reset | input | 1 | Synchronous active-high restart of the count |
| auto_reset_disable | input | 1 | 1 suppresses the power-up reset window |
| sel_a | input | 1 | Stage select, upper bit of the code |
| sel_b | input | 1 | Stage select, lower bit of the code |
| mode | input | 1 | 1 = divider, 0 = one-shot delay |
| polarity_sel | input | 1 | 1 inverts the output |
| timer_out | output | 1 | Timer output |

## Verification
The bench builds the block with a 6-bit counter and taps of 4, 3, 2 and 6 stages. With these values every select code fires its one-shot within a few dozen cycles, and a long-tap divider run crosses the counter wrap. A power-up window of two cycles is used, so the counting variant of the power-up logic is exercised rather than the single flip-flop. A bench-side reference model computes the expected output for each cycle, covering power-up with and without the auto start, repeated and held restarts, selection changes in mid-count, and mode changes after the one-shot has fired.

// File: rtl/pbt_pkg.sv
package pbt_pkg;

   // Stage-select code as seen on {sel_a, sel_b}
   typedef enum logic [1:0] {
      SEL_MID      = 2'b00,
      SEL_SHORT    = 2'b01,
      SEL_SHORTEST = 2'b10,
      SEL_LONG     = 2'b11
   } stage_sel_e;

   typedef enum logic {
      MODE_ONESHOT = 1'b0,
      MODE_DIVIDE  = 1'b1
   } out_mode_e;

   localparam int NUM_TAPS = 4;

endpackage

// File: rtl/pbt_por.sv
module pbt_por #(
   parameter int POR_LEN = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic auto_reset_disable,
   output logic por_reset
);

   localparam int PW = $clog2(POR_LEN + 1);

   logic window;

   generate
      if (POR_LEN < 1) begin : g_bad_len
         $error("pbt_por: POR_LEN must be at least 1");
      end

      if (POR_LEN == 1) begin : g_flop
         logic pend_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pend_q <= 1'b1;
            else        pend_q <= 1'b0;
         end
         assign window = pend_q;
      end else begin : g_count
         logic [PW-1:0] left_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              left_q <= PW'(POR_LEN);
            else if (left_q != '0)   left_q <= left_q - 1'b1;
         end
         assign window = (left_q != '0);
      end
   endgenerate

   assign por_reset = window & ~auto_reset_disable;

   // R2
   por_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !window |=> !window);

endmodule

// File: rtl/pbt_counter.sv
module pbt_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             any_reset,
   output logic [CNT_W-1:0] count
);

   logic run_q;

   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("pbt_counter: CNT_W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
         run_q <= 1'b0;
      end else if (any_reset) begin
         count <= '0;
         run_q <= 1'b1;
      end else if (run_q) begin
         count <= count + 1'b1;
      end
   end

   // R8
   clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      any_reset |=> (count == '0));

   // R3
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && !any_reset) |=> $stable(count));

   // R11
   advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && !any_reset) |=> (count == $past(count) + 1'b1));

endmodule

// File: rtl/pbt_tap_out.sv
module pbt_tap_out
   import pbt_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int TAP_00 = 13,
   parameter int TAP_01 = 10,
   parameter int TAP_10 = 8,
   parameter int TAP_11 = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             any_reset,
   input  logic [CNT_W-1:0] count,
   input  logic             sel_a,
   input  logic             sel_b,
   input  logic             mode,
   input  logic             polarity_sel,
   output logic             timer_out
);

   localparam int TAP_TBL [NUM_TAPS] = '{TAP_00, TAP_01, TAP_10, TAP_11};

   logic [NUM_TAPS-1:0] tap_bits;
   stage_sel_e          sel_code;
   out_mode_e           out_mode;
   logic                tap;
   logic                fired_q;
   logic                level;

   generate
      for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
         if (TAP_TBL[i] < 1 || TAP_TBL[i] > CNT_W) begin : g_bad_tap
            $error("pbt_tap_out: tap stage out of counter range");
         end else begin : g_ok
            assign tap_bits[i] = count[TAP_TBL[i]-1];
         end
      end
   endgenerate

   assign sel_code = stage_sel_e'({sel_a, sel_b});
   assign out_mode = out_mode_e'(mode);
   assign tap      = tap_bits[sel_code];
   assign level    = (out_mode == MODE_DIVIDE) ? tap : (fired_q | tap);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fired_q   <= 1'b0;
         timer_out <= 1'b0;
      end else if (any_reset) begin
         fired_q   <= 1'b0;
         timer_out <= polarity_sel;
      end else begin
         fired_q   <= fired_q | tap;
         timer_out <= polarity_sel ^ level;
      end
   end

   // R6
   latch_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fired_q && !any_reset) |=> fired_q);

   // R6
   fired_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode && fired_q && !any_reset) |=> (timer_out != $past(polarity_sel)));

   // R7
   reset_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      any_reset |=> (timer_out == $past(polarity_sel)));

endmodule

// File: rtl/pbt_timer.sv
module pbt_timer
   import pbt_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter int TAP_00  = 13,
   parameter int TAP_01  = 10,
   parameter int TAP_10  = 8,
   parameter int TAP_11  = 16,
   parameter int POR_LEN = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic master_reset,
   input  logic auto_reset_disable,
   input  logic sel_a,
   input  logic sel_b,
   input  logic mode,
   input  logic polarity_sel,
   output logic timer_out
);

   logic             por_reset;
   logic             any_reset;
   logic [CNT_W-1:0] count;

   pbt_por #(
      .POR_LEN (POR_LEN)
   ) u_por (
      .clk                (clk),
      .rst_n              (rst_n),
      .auto_reset_disable (auto_reset_disable),
      .por_reset          (por_reset)
   );

   assign any_reset = master_reset | por_reset;

   pbt_counter #(
      .CNT_W (CNT_W)
   ) u_counter (
      .clk       (clk),
      .rst_n     (rst_n),
      .any_reset (any_reset),
      .count     (count)
   );

   pbt_tap_out #(
      .CNT_W  (CNT_W),
      .TAP_00 (TAP_00),
      .TAP_01 (TAP_01),
      .TAP_10 (TAP_10),
      .TAP_11 (TAP_11)
   ) u_tap_out (
      .clk          (clk),
      .rst_n        (rst_n),
      .any_reset    (any_reset),
      .count        (count),
      .sel_a        (sel_a),
      .sel_b        (sel_b),
      .mode         (mode),
      .polarity_sel (polarity_sel),
      .timer_out    (timer_out)
   );

   // R8
   restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      master_reset |=> (timer_out == $past(polarity_sel)));

endmodule

// File: tb/tb_pbt_timer.sv
module tb_pbt_timer;

   localparam int W   = 6;
   localparam int T00 = 4;
   localparam int T01 = 3;
   localparam int T10 = 2;
   localparam int T11 = 6;
   localparam int PL  = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic master_reset = 1'b0;
   logic auto_reset_disable = 1'b0;
   logic sel_a = 1'b0;
   logic sel_b = 1'b0;
   logic mode = 1'b0;
   logic polarity_sel = 1'b0;
   logic timer_out;

   always #2 clk = ~clk;

   pbt_timer #(
      .CNT_W (W), .TAP_00 (T00), .TAP_01 (T01), .TAP_10 (T10), .TAP_11 (T11),
      .POR_LEN (PL)
   ) dut (
      .clk (clk), .rst_n (rst_n), .master_reset (master_reset),
      .auto_reset_disable (auto_reset_disable), .sel_a (sel_a), .sel_b (sel_b),
      .mode (mode), .polarity_sel (polarity_sel), .timer_out (timer_out)
   );

   typedef struct {
      logic  exp;
      string req;
   } item_t;

   item_t q[$];
   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // reference state
   int m_cnt;
   bit m_run;
   bit m_fired;
   bit m_out;
   int m_por;

   function automatic bit tap_of(int c, bit a, bit b);
      int n;
      case ({a, b})
         2'b00:   n = T00;
         2'b01:   n = T01;
         2'b10:   n = T10;
         default: n = T11;
      endcase
      return bit'((c >> (n - 1)) & 1);
   endfunction

   // driver: apply inputs at a falling edge, push the value expected after the next rising edge
   task automatic step(input bit mr, input bit ard, input bit a, input bit b,
                       input bit md, input bit pol, input string req);
      bit rs;
      bit t;
      master_reset = mr; auto_reset_disable = ard;
      sel_a = a; sel_b = b; mode = md; polarity_sel = pol;
      rs = mr | ((m_por != 0) && !ard);
      if (m_por != 0) m_por--;
      if (rs) begin
         m_cnt = 0; m_run = 1; m_fired = 0; m_out = pol;
      end else begin
         t = tap_of(m_cnt, a, b);
         m_out = pol ^ (md ? t : (m_fired | t));
         m_fired = m_fired | t;
         if (m_run) m_cnt = (m_cnt + 1) % (1 << W);
      end
      q.push_back('{m_out, req});
      @(negedge clk);
   endtask

   task automatic run(input int n, input bit a, input bit b, input bit md,
                      input bit pol, input string req);
      for (int i = 0; i < n; i++) step(1'b0, auto_reset_disable, a, b, md, pol, req);
   endtask

   task automatic power_up(input bit ard, input bit pol);
      rst_n = 1'b0;
      master_reset = 1'b0; auto_reset_disable = ard; polarity_sel = pol;
      m_cnt = 0; m_run = 0; m_fired = 0; m_out = 0; m_por = PL;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         checks++;
         if (timer_out !== 1'b0) begin
            fails++;
            $display("FAIL R1: timer_out=%b expected 0 while rst_n low", timer_out);
         end
      end
      rst_n = 1'b1;
   endtask

   // monitor: compare one queued item after each rising edge
   always @(posedge clk) begin
      item_t it;
      #1;
      if (q.size() > 0) begin
         it = q.pop_front();
         checks++;
         if (timer_out !== it.exp) begin
            fails++;
            $display("FAIL %s: timer_out=%b expected %b at %0t", it.req, timer_out, it.exp, $time);
         end
      end
   end

   initial begin
      @(negedge clk);
      // R1 then R2: auto start, divider on tap 4 (period 16)
      power_up(1'b0, 1'b0);
      for (int i = 0; i < PL; i++) step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R2");
      run(40, 1'b0, 1'b0, 1'b1, 1'b0, "R5");
      // R11: longest tap equals counter width, crosses the wrap
      run(140, 1'b1, 1'b1, 1'b1, 1'b0, "R11");

      // R3: auto start suppressed, inverted polarity, divider mode
      power_up(1'b1, 1'b1);
      for (int i = 0; i < 20; i++) step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, "R3");
      step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R8");
      run(10, 1'b1, 1'b0, 1'b0, 1'b1, "R7");

      // R4 and R6: one-shot on every select code, both polarities
      for (int p = 0; p < 2; p++) begin
         for (int s = 0; s < 4; s++) begin
            step(1'b1, 1'b1, s[1], s[0], 1'b0, p[0], "R8");
            run(40, s[1], s[0], 1'b0, p[0], (s == 0) ? "R6" : "R4");
         end
      end

      // R8: retrigger in mid-count, then a held restart
      step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R8");
      run(5, 1'b0, 1'b0, 1'b0, 1'b0, "R8");
      step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R8");
      run(12, 1'b0, 1'b0, 1'b0, 1'b0, "R8");
      for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R8");
      run(12, 1'b0, 1'b0, 1'b1, 1'b0, "R8");

      // R9: selection change without restart
      step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R8");
      run(3, 1'b0, 1'b0, 1'b0, 1'b0, "R9");
      run(10, 1'b1, 1'b0, 1'b0, 1'b0, "R9");

      // R10: divider view after firing, then back to one-shot
      run(20, 1'b0, 1'b1, 1'b1, 1'b0, "R10");
      run(8, 1'b0, 1'b1, 1'b0, 1'b0, "R10");

      @(posedge clk);
      #2;
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(4 * 150000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule